// File: doc/BRIEF.md
# Buffered Configuration Port Transfer Engine

This peripheral sits between a host register bus and a 32-bit configuration-port stream. It owns a one-frame buffer of 512 words that the host fills or empties through a word-addressed window. The host sets a byte count and a starting word index, then writes a direction code. That write both selects the direction and launches the transfer. In the configure direction the engine streams buffer words out over a valid/ready write channel. In the readback direction it accepts words from an inbound valid/ready channel and stores them into the buffer.

The host learns that a transfer has finished by polling a status word. Bit 0 of that word is a done flag. Four of its bits are fixed at one, and four more mirror the port's status inputs. A write of any value to the status address cancels a running transfer. Register and buffer writes, and new starts, are refused while a transfer is running. Buffer addressing wraps within the 512-word frame.

Top module: `cfg_xfer_engine`

## Requirements
- R1: After reset, the size and offset registers read 0, status bit 0 (done) reads 1, `cp_wr_valid` is 0 and `cp_rd_ready` is 0.
- R2: Buffer word N (0..511) is written and read at bus byte address N*4. Every bus read returns its data on `bus_rdata` in the cycle after `bus_re`. The direction address 0x808 reads as 0.
- R3: The size register at 0x800 keeps the low 12 bits of the written data. The offset register at 0x804 keeps the low 9 bits. Both read back zero-extended.
- R4: A write to 0x808 while idle starts a transfer: data bit 0 = 1 selects readback, and 0 selects configure. Status bit 0 reads 0 from the cycle after the write until the transfer ends.
- R5: In configure, `cp_wr_valid` is high while words remain. `cp_wr_data` carries buffer words starting at the offset, and the engine advances one word per cycle in which `cp_wr_valid` and `cp_wr_ready` are both high. Data holds steady while ready is low.
- R6: In readback, `cp_rd_ready` is high while words remain. Each cycle with `cp_rd_valid` and `cp_rd_ready` both high stores `cp_rd_data` at the next buffer word, counting from the offset.
- R7: A transfer moves min(size/4, 512) words, with size/4 rounded down. The stream handshake signal and the busy state drop in the cycle after the last handshake, and done reads 1 from then on.
- R8: Buffer addresses during a transfer wrap from word 511 to word 0.
- R9: A start with size below 4 leaves the engine idle: done stays 1 and no stream signal rises.
- R10: The status word at 0x80C has these bits: bit 0 = done, bits 4..1 = 1, bit 5 = `port_abort_n` level, bit 6 = `port_rip`, bit 7 = `port_align`, bit 8 = `port_cfg_err`. All other bits are 0.
- R11: A write of any value to 0x80C stops a running transfer. The next cycle shows no stream activity and done = 1.
- R12: While a transfer is running, writes to the size, offset and buffer addresses have no effect, and a further start write neither restarts the transfer nor changes its direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Bus byte address |
| bus_we | input | 1 | Bus write strobe |
| bus_re | input | 1 | Bus read strobe |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Bus read data, valid the cycle after bus_re |
| cp_wr_valid | output | 1 | Outbound word valid |
| cp_wr_ready | input | 1 | Outbound word accepted |
| cp_wr_data | output | 32 | Outbound word |
| cp_rd_valid | input | 1 | Inbound word valid |
| cp_rd_ready | output | 1 | Engine can take an inbound word |
| cp_rd_data | input | 32 | Inbound word |
| port_abort_n | input | 1 | Port abort status, active low |
| port_rip | input | 1 | Port read-in-progress flag |
| port_align | input | 1 | Port data-alignment flag |
| port_cfg_err | input | 1 | Port configuration-error flag |

## Verification
Each bus read returns its data one cycle after the strobe. A start or abort write changes the done bit and the stream signals in the next cycle, and the stream signals fall in the cycle after the final handshake. The bench drives inputs on falling edges. It reads status and register values through the strobe-plus-one-cycle path, and it judges stream handshakes at the falling edge before the rising edge that completes them. Because of this, every expected value is compared in the cycle in which the requirement says it becomes due.

// File: rtl/cxe_pkg.sv
package cxe_pkg;

    typedef enum logic {
        DIR_CONFIGURE = 1'b0,
        DIR_READBACK  = 1'b1
    } xfer_dir_e;

    // register selector decoded from byte address bits 3:2 (upper window)
    localparam logic [1:0] SEL_SIZE   = 2'd0;
    localparam logic [1:0] SEL_OFFSET = 2'd1;
    localparam logic [1:0] SEL_DIR    = 2'd2;
    localparam logic [1:0] SEL_STATUS = 2'd3;

    // status word bit positions
    localparam int ST_DONE   = 0;
    localparam int ST_ONE_LO = 1;
    localparam int ST_ONE_HI = 4;
    localparam int ST_ABORTN = 5;
    localparam int ST_RIP    = 6;
    localparam int ST_ALIGN  = 7;
    localparam int ST_CFGERR = 8;

endpackage

// File: rtl/cxe_buffer.sv
module cxe_buffer #(
    parameter int DEPTH  = 512,
    parameter int DATA_W = 32,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [AW-1:0]     waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [AW-1:0]     raddr_eng_i,
    output logic [DATA_W-1:0] rdata_eng_o,
    input  logic [AW-1:0]     raddr_host_i,
    output logic [DATA_W-1:0] rdata_host_o
);

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_eng_o  = mem_q[raddr_eng_i];
    assign rdata_host_o = mem_q[raddr_host_i];

endmodule

// File: rtl/cxe_seq.sv
module cxe_seq
    import cxe_pkg::*;
#(
    parameter int DEPTH  = 512,
    localparam int AW     = $clog2(DEPTH),
    localparam int CW     = AW + 1,
    localparam int SIZE_W = AW + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  xfer_dir_e         dir_i,
    input  logic [SIZE_W-1:0] size_i,
    input  logic [AW-1:0]     offset_i,
    input  logic              abort_i,
    input  logic              wr_ready_i,
    input  logic              rd_valid_i,
    output logic              busy_o,
    output logic              wr_valid_o,
    output logic              rd_ready_o,
    output logic              store_o,
    output logic [AW-1:0]     addr_o
);

    typedef struct packed {
        logic          busy;
        xfer_dir_e     dir;
        logic [AW-1:0] addr;
        logic [CW-1:0] left;
    } seq_t;

    seq_t s_d, s_q;

    logic [CW-1:0] req_words;
    logic [CW-1:0] len_words;
    logic          hs;

    always_comb begin
        req_words = size_i[SIZE_W-1:2];
        len_words = (req_words > CW'(DEPTH)) ? CW'(DEPTH) : req_words;
        hs = s_q.busy && ((s_q.dir == DIR_CONFIGURE) ? wr_ready_i : rd_valid_i);

        s_d = s_q;
        if (!s_q.busy) begin
            if (start_i && (len_words != '0)) begin
                s_d.busy = 1'b1;
                s_d.dir  = dir_i;
                s_d.addr = offset_i;
                s_d.left = len_words;
            end
        end else begin
            if (hs) begin
                s_d.addr = s_q.addr + 1'b1;
                s_d.left = s_q.left - 1'b1;
                if (s_q.left == CW'(1)) begin
                    s_d.busy = 1'b0;
                end
            end
        end
        if (abort_i) begin
            s_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{busy: 1'b0, dir: DIR_CONFIGURE, addr: '0, left: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o     = s_q.busy;
    assign wr_valid_o = s_q.busy && (s_q.dir == DIR_CONFIGURE);
    assign rd_ready_o = s_q.busy && (s_q.dir == DIR_READBACK);
    assign store_o    = rd_ready_o && rd_valid_i;
    assign addr_o     = s_q.addr;

    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> !busy_o) else $error("abort did not idle");          // R11
    AST_START_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> (s_q.dir == $past(s_q.dir))) else $error("restart"); // R12
    AST_LEFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (hs && !abort_i) |=> (s_q.left == $past(s_q.left) - 1'b1)) else $error("count"); // R7
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (hs && !abort_i) |=> (addr_o == $past(addr_o) + 1'b1)) else $error("addr"); // R8
    AST_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && (size_i < SIZE_W'(4))) |=> !busy_o) else $error("zero"); // R9

endmodule

// File: rtl/cxe_regs.sv
module cxe_regs
    import cxe_pkg::*;
#(
    parameter int DEPTH  = 512,
    parameter int DATA_W = 32,
    localparam int AW     = $clog2(DEPTH),
    localparam int SIZE_W = AW + 3,
    localparam int ADDR_W = AW + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              busy_i,
    input  logic              port_abort_n,
    input  logic              port_rip,
    input  logic              port_align,
    input  logic              port_cfg_err,
    input  logic [DATA_W-1:0] buf_rdata_i,
    output logic [AW-1:0]     buf_idx_o,
    output logic              buf_we_o,
    output logic              start_o,
    output xfer_dir_e         dir_o,
    output logic              abort_o,
    output logic [SIZE_W-1:0] size_o,
    output logic [AW-1:0]     offset_o
);

    typedef struct packed {
        logic [SIZE_W-1:0] size;
        logic [AW-1:0]     offset;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    regs_t r_d, r_q;

    logic              in_regs;
    logic [1:0]        sel;
    logic [DATA_W-1:0] status_w;
    logic [DATA_W-1:0] rd_mux;
    logic [1:0]        unused_addr_lsb;

    assign unused_addr_lsb = bus_addr[1:0];

    always_comb begin
        in_regs = bus_addr[ADDR_W-1];
        sel     = bus_addr[3:2];

        status_w = '0;
        status_w[ST_DONE]             = !busy_i;
        status_w[ST_ONE_HI:ST_ONE_LO] = '1;
        status_w[ST_ABORTN]           = port_abort_n;
        status_w[ST_RIP]              = port_rip;
        status_w[ST_ALIGN]            = port_align;
        status_w[ST_CFGERR]           = port_cfg_err;

        if (!in_regs) begin
            rd_mux = buf_rdata_i;
        end else begin
            case (sel)
                SEL_SIZE:   rd_mux = DATA_W'(r_q.size);
                SEL_OFFSET: rd_mux = DATA_W'(r_q.offset);
                SEL_STATUS: rd_mux = status_w;
                default:    rd_mux = '0;
            endcase
        end

        buf_we_o = bus_we && !in_regs && !busy_i;
        start_o  = bus_we && in_regs && (sel == SEL_DIR) && !busy_i;
        abort_o  = bus_we && in_regs && (sel == SEL_STATUS);
        dir_o    = bus_wdata[0] ? DIR_READBACK : DIR_CONFIGURE;

        r_d = r_q;
        if (bus_we && in_regs && !busy_i) begin
            if (sel == SEL_SIZE) begin
                r_d.size = bus_wdata[SIZE_W-1:0];
            end
            if (sel == SEL_OFFSET) begin
                r_d.offset = bus_wdata[AW-1:0];
            end
        end
        if (bus_re) begin
            r_d.rdata = rd_mux;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign buf_idx_o = bus_addr[AW+1:2];
    assign bus_rdata = r_q.rdata;
    assign size_o    = r_q.size;
    assign offset_o  = r_q.offset;

    AST_SIZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> $stable(size_o)) else $error("size changed");      // R12
    AST_OFFSET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> $stable(offset_o)) else $error("offset changed");  // R12
    AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> $stable(bus_rdata)) else $error("rdata moved");   // R2

endmodule

// File: rtl/cfg_xfer_engine.sv
module cfg_xfer_engine
    import cxe_pkg::*;
#(
    parameter int DEPTH  = 512,
    parameter int DATA_W = 32,
    localparam int AW     = $clog2(DEPTH),
    localparam int SIZE_W = AW + 3,
    localparam int ADDR_W = AW + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              cp_wr_valid,
    input  logic              cp_wr_ready,
    output logic [DATA_W-1:0] cp_wr_data,
    input  logic              cp_rd_valid,
    output logic              cp_rd_ready,
    input  logic [DATA_W-1:0] cp_rd_data,
    input  logic              port_abort_n,
    input  logic              port_rip,
    input  logic              port_align,
    input  logic              port_cfg_err
);

    logic              busy;
    logic              start;
    logic              abort;
    xfer_dir_e         dir;
    logic [SIZE_W-1:0] size;
    logic [AW-1:0]     offset;
    logic [AW-1:0]     host_idx;
    logic              host_we;
    logic              eng_store;
    logic [AW-1:0]     eng_addr;
    logic [DATA_W-1:0] host_rdata;
    logic              mem_we;
    logic [AW-1:0]     mem_waddr;
    logic [DATA_W-1:0] mem_wdata;

    cxe_regs #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_addr     (bus_addr),
        .bus_we       (bus_we),
        .bus_re       (bus_re),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .busy_i       (busy),
        .port_abort_n (port_abort_n),
        .port_rip     (port_rip),
        .port_align   (port_align),
        .port_cfg_err (port_cfg_err),
        .buf_rdata_i  (host_rdata),
        .buf_idx_o    (host_idx),
        .buf_we_o     (host_we),
        .start_o      (start),
        .dir_o        (dir),
        .abort_o      (abort),
        .size_o       (size),
        .offset_o     (offset)
    );

    cxe_seq #(.DEPTH(DEPTH)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .dir_i      (dir),
        .size_i     (size),
        .offset_i   (offset),
        .abort_i    (abort),
        .wr_ready_i (cp_wr_ready),
        .rd_valid_i (cp_rd_valid),
        .busy_o     (busy),
        .wr_valid_o (cp_wr_valid),
        .rd_ready_o (cp_rd_ready),
        .store_o    (eng_store),
        .addr_o     (eng_addr)
    );

    always_comb begin
        mem_we    = eng_store || host_we;
        mem_waddr = eng_store ? eng_addr : host_idx;
        mem_wdata = eng_store ? cp_rd_data : bus_wdata;
    end

    cxe_buffer #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_buf (
        .clk          (clk),
        .we_i         (mem_we),
        .waddr_i      (mem_waddr),
        .wdata_i      (mem_wdata),
        .raddr_eng_i  (eng_addr),
        .rdata_eng_o  (cp_wr_data),
        .raddr_host_i (host_idx),
        .rdata_host_o (host_rdata)
    );

    AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_we && eng_store)) else $error("two writers");           // R12
    AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
        !(cp_wr_valid && cp_rd_ready)) else $error("both directions"); // R6
    AST_WR_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_wr_valid && !cp_wr_ready && !abort) |=> $stable(cp_wr_data)) else $error("data moved"); // R5

endmodule

// File: tb/cfg_xfer_engine_test.sv
`timescale 1ns/1ps
module cfg_xfer_engine_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cp_wr_valid;
    logic        cp_wr_ready = 1'b0;
    logic [31:0] cp_wr_data;
    logic        cp_rd_valid = 1'b0;
    logic        cp_rd_ready;
    logic [31:0] cp_rd_data = '0;
    logic        port_abort_n = 1'b1;
    logic        port_rip = 1'b0;
    logic        port_align = 1'b0;
    logic        port_cfg_err = 1'b0;

    int unsigned errors = 0;
    int unsigned checks = 0;
    logic [31:0] model [512];
    logic [31:0] rd;

    always #2 clk = ~clk;

    cfg_xfer_engine uut (.*);

    function automatic logic [31:0] exp_status(logic done, logic an, logic rip, logic al, logic err);
        return {23'd0, err, al, rip, an, 4'hF, done};
    endfunction

    function automatic int exp_words(int size);
        int w = size / 4;
        return (w > 512) ? 512 : w;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    task automatic run_cfg(int off, int size, string req);
        int n = exp_words(size);
        int cnt = 0;
        bus_write(12'h800, size);
        bus_write(12'h804, off);
        bus_write(12'h808, 32'h0);
        while (cnt < n) begin
            @(negedge clk);
            if (cp_wr_valid) begin
                cp_wr_ready = ($urandom % 4) != 0;
                if (cp_wr_ready) begin
                    chk(req, cp_wr_data, model[(off + cnt) % 512]);
                    cnt++;
                end
            end else begin
                cp_wr_ready = 1'b0;
            end
        end
        @(negedge clk);
        cp_wr_ready = 1'b0;
        chk("R7 valid drops after last word", {31'd0, cp_wr_valid}, 32'd0);
        bus_read(12'h80C, rd);
        chk("R7 done after configure", {31'd0, rd[0]}, 32'd1);
    endtask

    task automatic run_rb(int off, int size, string req);
        int n = exp_words(size);
        int cnt = 0;
        bus_write(12'h800, size);
        bus_write(12'h804, off);
        bus_write(12'h808, 32'h1);
        while (cnt < n) begin
            @(negedge clk);
            if (cp_rd_ready && (($urandom % 3) != 0)) begin
                cp_rd_valid = 1'b1;
                cp_rd_data  = $urandom;
                model[(off + cnt) % 512] = cp_rd_data;
                cnt++;
            end else begin
                cp_rd_valid = 1'b0;
            end
        end
        @(negedge clk);
        cp_rd_valid = 1'b0;
        chk("R7 ready drops after last word", {31'd0, cp_rd_ready}, 32'd0);
        for (int i = 0; i < n && i < 48; i++) begin
            bus_read(12'(((off + i) % 512) * 4), rd);
            chk(req, rd, model[(off + i) % 512]);
        end
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 wr_valid", {31'd0, cp_wr_valid}, 32'd0);
        chk("R1 rd_ready", {31'd0, cp_rd_ready}, 32'd0);
        bus_read(12'h800, rd); chk("R1 size", rd, 32'd0);
        bus_read(12'h804, rd); chk("R1 offset", rd, 32'd0);
        bus_read(12'h80C, rd); chk("R1 status", rd, exp_status(1, 1, 0, 0, 0));

        // R2 buffer window
        for (int i = 0; i < 512; i++) begin
            model[i] = $urandom;
            bus_write(12'(i * 4), model[i]);
        end
        bus_read(12'h000, rd); chk("R2 word 0", rd, model[0]);
        bus_read(12'h004, rd); chk("R2 word 1", rd, model[1]);
        bus_read(12'h7FC, rd); chk("R2 word 511", rd, model[511]);
        bus_read(12'h808, rd); chk("R2 direction reads 0", rd, 32'd0);

        // R3 register read-back widths
        bus_write(12'h800, 32'hFFFF_F123);
        bus_read(12'h800, rd); chk("R3 size 12 bits", rd, 32'h123);
        bus_write(12'h804, 32'hFFFF_FE05);
        bus_read(12'h804, rd); chk("R3 offset 9 bits", rd, 32'h005);

        // R10 status layout
        port_abort_n = 1'b0; port_rip = 1'b1; port_align = 1'b0; port_cfg_err = 1'b1;
        bus_read(12'h80C, rd); chk("R10 status mix a", rd, exp_status(1, 0, 1, 0, 1));
        port_abort_n = 1'b1; port_rip = 1'b0; port_align = 1'b1; port_cfg_err = 1'b0;
        bus_read(12'h80C, rd); chk("R10 status mix b", rd, exp_status(1, 1, 0, 1, 0));
        port_align = 1'b0;

        // R5 directed configure, R8 wrap both directions
        run_cfg(3, 20, "R5 configure word");
        run_cfg(510, 16, "R8 configure wrap word");
        run_rb(509, 20, "R8 readback wrap word");
        run_rb(40, 13, "R6 readback word");

        // R9 sub-word size
        bus_write(12'h800, 32'd2);
        bus_write(12'h808, 32'd0);
        chk("R9 no valid", {31'd0, cp_wr_valid}, 32'd0);
        bus_read(12'h80C, rd); chk("R9 done stays", {31'd0, rd[0]}, 32'd1);

        // R4 start, R12 ignore while busy, R11 abort
        bus_write(12'h800, 32'd160);
        bus_write(12'h804, 32'd0);
        bus_write(12'h808, 32'd1);
        chk("R4 readback ready", {31'd0, cp_rd_ready}, 32'd1);
        bus_read(12'h80C, rd); chk("R4 done low while busy", {31'd0, rd[0]}, 32'd0);
        bus_write(12'h800, 32'd8);
        bus_write(12'h804, 32'd7);
        bus_write(12'h000, ~model[0]);
        bus_write(12'h808, 32'd0);
        chk("R12 direction kept", {30'd0, cp_wr_valid, cp_rd_ready}, 32'd1);
        bus_write(12'h80C, 32'hFEFE);
        chk("R11 ready drops", {31'd0, cp_rd_ready}, 32'd0);
        bus_read(12'h80C, rd); chk("R11 done after abort", {31'd0, rd[0]}, 32'd1);
        bus_read(12'h800, rd); chk("R12 size kept", rd, 32'd160);
        bus_read(12'h804, rd); chk("R12 offset kept", rd, 32'd0);
        bus_read(12'h000, rd); chk("R12 buffer kept", rd, model[0]);

        // R11 abort during configure stall
        cp_wr_ready = 1'b0;
        bus_write(12'h808, 32'd0);
        chk("R5 valid during stall", {31'd0, cp_wr_valid}, 32'd1);
        bus_write(12'h80C, 32'd0);
        chk("R11 valid drops", {31'd0, cp_wr_valid}, 32'd0);

        // R7 oversize request clamps to a full frame
        run_rb(100, 32'hFFC, "R7 full frame word");
        run_cfg(0, 2048, "R7 full frame configure");

        // random mix
        for (int k = 0; k < 12; k++) begin
            int off = $urandom % 512;
            int sz  = (($urandom % 40) + 1) * 4 + ($urandom % 4);
            if ($urandom % 2) run_rb(off, sz, "R6 random readback");
            else              run_cfg(off, sz, "R5 random configure");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule